// File: doc/BRIEF.md
# Halting Offset-Range Cascaded Counter

This block is an 8-bit up-counter assembled from two identical 4-bit synchronous counter slices. Each slice has a synchronous active-low clear, a synchronous active-low load, a pair of count enables (one shared "parallel" enable and one "trickle" enable that also gates the slice's carry out) and a carry output. The low slice's trickle enable is tied on, and its carry feeds the high slice's trickle enable, so the carry at the end of the chain is high exactly when the whole count is all ones. The master count enable drives the parallel enable of every slice.

After reset the count starts at 0 and climbs. Once it first reaches 255 it stays inside a 193-state loop from 63 to 255: at 255 it parks, with the terminal flag raised, until the active-low go input is driven low; the next clock edge then loads 63 and counting resumes. The go input has no effect in any other state. The terminal flag comes from the carry chain, so it stays high while the counter is parked and while the master enable is low.

The reset input clears the count at once when it falls. Its release passes through a two-stage synchronizer whose output acts as the slices' synchronous clear, so counting starts on a known edge.

Top module: `halt_ctr`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `at_max` is 0; a fall of `rst_n` between clock edges clears `count` without waiting for an edge.
- R2: After `rst_n` rises, `count` stays 0 across the first two rising edges of `clk`; the third edge is the first that can change it.
- R3: When `count` is below 255 and `cnt_en` is 1, each rising edge adds 1 to `count`, including the carry from the low 4 bits into the high 4 bits (for example 79 goes to 80).
- R4: When `count` is below 255 and `cnt_en` is 0, `count` keeps its value.
- R5: `at_max` is 1 exactly when `count` is 255, whether `cnt_en` is 1 or 0.
- R6: When `count` is 255 and `go_n` is 1, `count` stays 255 on each edge for either value of `cnt_en`; it never wraps to 0.
- R7: When `count` is 255 and `go_n` is 0, the next rising edge sets `count` to 63, for either value of `cnt_en`.
- R8: When `count` is not 255, `go_n` has no effect on `count`.
- R9: After the count has first reached 255, with `cnt_en` held at 1 and `go_n` held at 0, the sequence 63, 64, …, 255 repeats every 193 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| cnt_en | input | 1 | Master count enable, drives every slice's parallel enable |
| go_n | input | 1 | Active-low restart request, used only at the terminal state |
| count | output | 8 | Current count value |
| at_max | output | 1 | Terminal flag, high when the count is 255 |

## Verification
The bench builds the block with its default values: two 4-bit slices and a base of 63. With these values the whole 193-state loop, the park at 255 and the carry between the two slices each take only a few hundred cycles. A vector table drives long runs with the enable and go inputs in different combinations, and a cycle-by-cycle reference model checks every edge. Directed steps cover reset release timing and a reset that falls in the middle of a clock period.

// File: rtl/halt_ctr_pkg.sv
package halt_ctr_pkg;

  localparam int unsigned DEF_SLICE_W = 4;
  localparam int unsigned DEF_SLICES  = 2;
  localparam int unsigned DEF_BASE    = 63;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_HOLD  = 2'd3
  } slice_op_e;

endpackage

// File: rtl/halt_ctr_rstsync.sv
module halt_ctr_rstsync
  import halt_ctr_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic clr_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign clr_n = sync_q[STAGES-1];

endmodule

// File: rtl/halt_ctr_slice.sv
module halt_ctr_slice
  import halt_ctr_pkg::*;
#(
  parameter int unsigned W = DEF_SLICE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         enp,
  input  logic         ent,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         rco
);

  slice_op_e    op;
  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  // clear beats load, load beats counting
  always_comb begin
    if (!clr_n) begin
      op = OP_CLEAR;
    end else if (!ld_n) begin
      op = OP_LOAD;
    end else if (enp && ent) begin
      op = OP_STEP;
    end else begin
      op = OP_HOLD;
    end
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: q_d = '0;
      OP_LOAD:  q_d = din;
      OP_STEP:  q_d = q_r + W'(1);
      default:  q_d = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_d;
    end
  end

  assign q   = q_r;
  assign rco = ent & (&q_r);

endmodule

// File: rtl/halt_ctr.sv
module halt_ctr
  import halt_ctr_pkg::*;
#(
  parameter int unsigned SLICE_W = DEF_SLICE_W,
  parameter int unsigned SLICES  = DEF_SLICES,
  parameter int unsigned BASE    = DEF_BASE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cnt_en,
  input  logic                      go_n,
  output logic [SLICE_W*SLICES-1:0] count,
  output logic                      at_max
);

  localparam int unsigned CW = SLICE_W * SLICES;
  localparam logic [CW-1:0] BASE_V = CW'(BASE);

  logic          clr_n_sync;
  logic          reload_n;
  logic          step_en;
  logic [SLICES:0] ent_chain;
  logic [SLICES-1:0] rco_vec;
  logic [CW-1:0] q_all;

  halt_ctr_rstsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (clr_n_sync)
  );

  assign ent_chain[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 0; gi < SLICES; gi++) begin : g_slice
      halt_ctr_slice #(.W(SLICE_W)) u_slice (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n_sync),
        .ld_n  (reload_n),
        .enp   (step_en),
        .ent   (ent_chain[gi]),
        .din   (BASE_V[gi*SLICE_W +: SLICE_W]),
        .q     (q_all[gi*SLICE_W +: SLICE_W]),
        .rco   (rco_vec[gi])
      );
      assign ent_chain[gi+1] = rco_vec[gi];
    end
  endgenerate

  // terminal decode is the end of the carry chain, independent of cnt_en
  assign at_max   = ent_chain[SLICES];
  assign reload_n = ~((~go_n) & at_max);
  assign step_en  = cnt_en & ~at_max;
  assign count    = q_all;

endmodule

// File: rtl/halt_ctr_chk.sv
module halt_ctr_chk #(
  parameter int unsigned CW   = 8,
  parameter int unsigned BASE = 63
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_n,
  input logic          cnt_en,
  input logic          go_n,
  input logic [CW-1:0] count,
  input logic          at_max
);

  localparam logic [CW-1:0] TOP_V  = '1;
  localparam logic [CW-1:0] BASE_V = CW'(BASE);

  p_sync_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> count == '0);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !at_max && cnt_en) |=> count == CW'($past(count) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !at_max && !cnt_en) |=> $stable(count));

  p_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    at_max == (count == TOP_V));

  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && at_max && go_n) |=> (count == TOP_V));

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && at_max && !go_n) |=> (count == BASE_V));

endmodule

bind halt_ctr halt_ctr_chk #(.CW(CW), .BASE(BASE)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .clr_n  (clr_n_sync),
  .cnt_en (cnt_en),
  .go_n   (go_n),
  .count  (count),
  .at_max (at_max)
);

// File: tb/tb_halt_ctr.sv
module tb_halt_ctr;

  localparam int NV = 12;

  logic       clk;
  logic       rst_n;
  logic       cnt_en;
  logic       go_n;
  logic [7:0] count;
  logic       at_max;

  int checks;
  int errors;
  int exp_cnt;

  // {en, go_n, edges[8:0], count[7:0], flag}
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b1, 9'd99,  8'd100, 1'b0},  // R3 climb from 1
    {1'b0, 1'b1, 9'd20,  8'd100, 1'b0},  // R4 disabled hold
    {1'b0, 1'b0, 9'd7,   8'd100, 1'b0},  // R8 go while not at top
    {1'b1, 1'b1, 9'd155, 8'd255, 1'b1},  // R3 reach top
    {1'b1, 1'b1, 9'd10,  8'd255, 1'b1},  // R6 park with enable high
    {1'b0, 1'b1, 9'd3,   8'd255, 1'b1},  // R5 flag with enable low
    {1'b0, 1'b0, 9'd1,   8'd63,  1'b0},  // R7 reload without enable
    {1'b1, 1'b0, 9'd192, 8'd255, 1'b1},  // R8 go held low through run
    {1'b1, 1'b0, 9'd1,   8'd63,  1'b0},  // R9 loop closes after 193
    {1'b1, 1'b1, 9'd1,   8'd64,  1'b0},  // R9 second lap begins
    {1'b1, 1'b0, 9'd15,  8'd79,  1'b0},  // R8 go low mid range
    {1'b1, 1'b1, 9'd1,   8'd80,  1'b0}   // R3 carry into high slice
  };

  string vtag [NV];

  halt_ctr dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .go_n   (go_n),
    .count  (count),
    .at_max (at_max)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vtag = '{"R3", "R4", "R8", "R3", "R6", "R5", "R7", "R8", "R9", "R9", "R8", "R3"};
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    cnt_en = 1'b0;
    go_n   = 1'b1;
    #3;
    check("R1 count in reset", int'(count), 0);
    check("R1 flag in reset", int'(at_max), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n  = 1'b1;
    cnt_en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 first edge after release", int'(count), 0);
    @(posedge clk); @(negedge clk);
    check("R2 second edge after release", int'(count), 0);
    @(posedge clk); @(negedge clk);
    check("R2 third edge counts", int'(count), 1);
    exp_cnt = 1;

    for (int v = 0; v < NV; v++) begin
      cnt_en = VEC[v][19];
      go_n   = VEC[v][18];
      for (int e = 0; e < int'(VEC[v][17:9]); e++) begin
        if (exp_cnt == 255) begin
          exp_cnt = go_n ? 255 : 63;
        end else if (cnt_en) begin
          exp_cnt = exp_cnt + 1;
        end
        @(posedge clk); @(negedge clk);
        check(exp_cnt == 255 ? "R6 model step" : "R3 R4 model step", int'(count), exp_cnt);
        check("R5 flag tracks model", int'(at_max), (exp_cnt == 255) ? 1 : 0);
      end
      check({vtag[v], " vector count"}, int'(count), int'(VEC[v][8:1]));
      check({vtag[v], " vector flag"}, int'(at_max), int'(VEC[v][0]));
    end

    // R1: reset falling mid-period clears at once
    #2;
    rst_n = 1'b0;
    #1;
    check("R1 async clear mid period", int'(count), 0);
    check("R1 flag after async clear", int'(at_max), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule